// File: doc/BRIEF.md
# Instruction Cycle State Sequencer

This block is the control-unit state machine of a small processor. It walks each instruction through its phases: next-address calculation, instruction fetch, decode, operand address calculation, operand fetch, data operation and operand store. Each phase is shown on a one-hot strobe vector that the datapath uses to steer its own registers. The sequencer also owns the program counter. It raises memory read and write requests and waits on a ready handshake. It pulses the instruction-register load and issues the increment and load enables for the program counter.

Decoded hints from the instruction decoder are read during the decode phase. One says the instruction references memory operands, one says it writes a result back, and one says it transfers control. The operand phases are skipped when they are not needed. They repeat while the datapath asks for another operand. After execution an interrupt check phase runs. With nothing pending the sequencer returns to address calculation. With an interrupt pending it pulses a context-save strobe for an external register bank and loads the program counter with a fixed handler address.

Top module: `instr_cycle_seq`

## Requirements
- R1: While `rst_ni` is low, and at once when it falls, the phase is address calculation (`phase_o` = 1) and `pc_o` is zero. `mem_rd_o`, `mem_wr_o` and `ctx_save_o` are low.
- R2: `phase_o` always has exactly one bit set. The bit indices are: 0 address calculation, 1 fetch, 2 decode, 3 operand address, 4 operand fetch, 5 data operation, 6 operand store, 7 interrupt check, 8 context save.
- R3: Phases that do not touch memory last one cycle. Address calculation goes to fetch and fetch goes to decode. Decode goes to operand address when `has_mem_opnd_i` is high, otherwise to data operation. Data operation goes to operand store when the store hint was high in decode, otherwise to interrupt check.
- R4: Fetch and operand fetch hold `mem_rd_o` high, and operand store holds `mem_wr_o` high. Each stays in place until `mem_ready_i` is high at a clock edge, then moves on at that edge.
- R5: At the edge that completes a fetch, `ir_load_o` and `pc_inc_o` are high for that single cycle, and `pc_o` increases by one.
- R6: At the edge that completes an operand fetch, a high `more_opnd_i` returns the sequencer to operand address calculation. A low `more_opnd_i` moves it on to data operation.
- R7: In data operation of an instruction whose jump hint was high in decode, `pc_load_o` is high and `pc_o` takes `jump_target_i` at the next edge.
- R8: In interrupt check, a low `irq_pending_i` leads to address calculation and a high one leads to context save.
- R9: Context save lasts one cycle with `ctx_save_o` and `pc_load_o` high. `pc_o` then equals the `VECTOR` parameter, overriding any jump target, and the next phase is address calculation.
- R10: `irq_pending_i` has no effect in any phase other than interrupt check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_ready_i | input | 1 | Memory completes the current read or write |
| has_mem_opnd_i | input | 1 | Decode hint: instruction has memory operands |
| has_store_i | input | 1 | Decode hint: result is written to memory |
| is_jump_i | input | 1 | Decode hint: control transfer |
| more_opnd_i | input | 1 | Another operand follows the current operand fetch |
| irq_pending_i | input | 1 | Interrupt request pending |
| jump_target_i | input | AW | Control-transfer destination |
| phase_o | output | 9 | One-hot phase strobes |
| pc_o | output | AW | Program counter |
| pc_inc_o | output | 1 | PC increment enable |
| pc_load_o | output | 1 | PC load enable |
| ir_load_o | output | 1 | Instruction register load enable |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| ctx_save_o | output | 1 | Context save pulse to the external register bank |

## Verification
The bench adds wait states to every memory phase and counts cycles per instruction. A sequencer that advanced before ready, or that dropped the request early, would show a wrong cycle count and wrong read and write tallies. Instructions with several operands check the operand loop: a design that ignored `more_opnd_i` would issue too few operand reads. An instruction that both jumps and takes an interrupt checks that the handler address wins over the jump target. A request that is high in every phase except interrupt check must leave the program running without a context save. A reset dropped in the middle of a waited operand fetch must clear the phase and the program counter at once, without waiting for a clock edge.

// File: rtl/ics_pkg.sv
package ics_pkg;
  localparam int unsigned NUM_PH = 9;
  localparam int unsigned PH_W   = $clog2(NUM_PH);

  typedef enum logic [PH_W-1:0] {
    PH_IAC  = 4'd0,  // next-address calculation
    PH_IF   = 4'd1,  // instruction fetch
    PH_IOD  = 4'd2,  // decode
    PH_OAC  = 4'd3,  // operand address calculation
    PH_OF   = 4'd4,  // operand fetch
    PH_DO   = 4'd5,  // data operation
    PH_OS   = 4'd6,  // operand store
    PH_ICHK = 4'd7,  // interrupt check
    PH_ISAV = 4'd8   // context save + vector
  } phase_e;
endpackage

// File: rtl/ics_fsm.sv
module ics_fsm
  import ics_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   mem_ready_i,
  input  logic   has_mem_opnd_i,
  input  logic   has_store_i,
  input  logic   is_jump_i,
  input  logic   more_opnd_i,
  input  logic   irq_pending_i,
  output phase_e state_o,
  output logic   jump_o
);
  phase_e state_q, state_d;
  logic   store_q, jump_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IAC:  state_d = PH_IF;
      PH_IF:   if (mem_ready_i) state_d = PH_IOD;
      PH_IOD:  state_d = has_mem_opnd_i ? PH_OAC : PH_DO;
      PH_OAC:  state_d = PH_OF;
      PH_OF:   if (mem_ready_i) state_d = more_opnd_i ? PH_OAC : PH_DO;
      PH_DO:   state_d = store_q ? PH_OS : PH_ICHK;
      PH_OS:   if (mem_ready_i) state_d = PH_ICHK;
      PH_ICHK: state_d = irq_pending_i ? PH_ISAV : PH_IAC;
      PH_ISAV: state_d = PH_IAC;
      default: state_d = PH_IAC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IAC;
      store_q <= 1'b0;
      jump_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // hints are only trusted while the decoder presents this instruction
      if (state_q == PH_IOD) begin
        store_q <= has_store_i;
        jump_q  <= is_jump_i;
      end
    end
  end

  assign state_o = state_q;
  assign jump_o  = jump_q;
endmodule

// File: rtl/ics_strobe.sv
module ics_strobe
  import ics_pkg::*;
(
  input  phase_e            state_i,
  input  logic              mem_ready_i,
  input  logic              jump_i,
  output logic [NUM_PH-1:0] phase_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              ir_load_o,
  output logic              pc_inc_o,
  output logic              pc_load_o,
  output logic              vec_sel_o,
  output logic              ctx_save_o
);
  for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
    assign phase_o[g] = (state_i == phase_e'(PH_W'(g)));
  end

  logic fetch_done;
  assign fetch_done = (state_i == PH_IF) && mem_ready_i;

  assign mem_rd_o   = (state_i == PH_IF) || (state_i == PH_OF);
  assign mem_wr_o   = (state_i == PH_OS);
  assign ir_load_o  = fetch_done;
  assign pc_inc_o   = fetch_done;
  assign ctx_save_o = (state_i == PH_ISAV);
  assign vec_sel_o  = ctx_save_o;
  assign pc_load_o  = ((state_i == PH_DO) && jump_i) || ctx_save_o;
endmodule

// File: rtl/ics_pc.sv
module ics_pc #(
  parameter int unsigned       AW     = 16,
  parameter logic [AW-1:0]     VECTOR = 16'h0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic          vec_sel_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (load_i) pc_q <= vec_sel_i ? VECTOR : target_i;
    else if (inc_i)  pc_q <= pc_q + AW'(1);
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq #(
  parameter int unsigned   AW     = 16,
  parameter logic [AW-1:0] VECTOR = 16'h0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mem_ready_i,
  input  logic          has_mem_opnd_i,
  input  logic          has_store_i,
  input  logic          is_jump_i,
  input  logic          more_opnd_i,
  input  logic          irq_pending_i,
  input  logic [AW-1:0] jump_target_i,
  output logic [8:0]    phase_o,
  output logic [AW-1:0] pc_o,
  output logic          pc_inc_o,
  output logic          pc_load_o,
  output logic          ir_load_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          ctx_save_o
);
  import ics_pkg::*;

  phase_e state;
  logic   jump_q;
  logic   vec_sel;

  ics_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mem_ready_i    (mem_ready_i),
    .has_mem_opnd_i (has_mem_opnd_i),
    .has_store_i    (has_store_i),
    .is_jump_i      (is_jump_i),
    .more_opnd_i    (more_opnd_i),
    .irq_pending_i  (irq_pending_i),
    .state_o        (state),
    .jump_o         (jump_q)
  );

  ics_strobe u_strobe (
    .state_i     (state),
    .mem_ready_i (mem_ready_i),
    .jump_i      (jump_q),
    .phase_o     (phase_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .ir_load_o   (ir_load_o),
    .pc_inc_o    (pc_inc_o),
    .pc_load_o   (pc_load_o),
    .vec_sel_o   (vec_sel),
    .ctx_save_o  (ctx_save_o)
  );

  ics_pc #(.AW(AW), .VECTOR(VECTOR)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (pc_inc_o),
    .load_i    (pc_load_o),
    .vec_sel_i (vec_sel),
    .target_i  (jump_target_i),
    .pc_o      (pc_o)
  );
endmodule

// File: rtl/ics_checker.sv
module ics_checker
  import ics_pkg::*;
#(
  parameter int unsigned   AW     = 16,
  parameter logic [AW-1:0] VECTOR = 16'h0100
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_ready_i,
  input logic          more_opnd_i,
  input logic          irq_pending_i,
  input logic [AW-1:0] jump_target_i,
  input logic [8:0]    phase_o,
  input logic [AW-1:0] pc_o,
  input logic          pc_load_o,
  input logic          ir_load_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          ctx_save_o
);
  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_o) == 1);

  p_wait_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) && !mem_ready_i |=> $stable(phase_o));

  p_fetch_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[PH_IF] && mem_ready_i |=> phase_o[PH_IOD]);

  p_pc_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_o |=> pc_o == $past(pc_o) + AW'(1));

  p_more_opnd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[PH_OF] && mem_ready_i && more_opnd_i |=> phase_o[PH_OAC]);

  p_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[PH_DO] && pc_load_o |=> pc_o == $past(jump_target_i));

  p_no_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[PH_ICHK] && !irq_pending_i |=> phase_o[PH_IAC]);

  p_vector_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_save_o |=> !ctx_save_o && pc_o == VECTOR && phase_o[PH_IAC]);

  p_irq_only_ichk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[PH_ISAV] |-> $past(phase_o[PH_ICHK]) && $past(irq_pending_i));
endmodule

bind instr_cycle_seq ics_checker #(.AW(AW), .VECTOR(VECTOR)) u_ics_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_ready_i   (mem_ready_i),
  .more_opnd_i   (more_opnd_i),
  .irq_pending_i (irq_pending_i),
  .jump_target_i (jump_target_i),
  .phase_o       (phase_o),
  .pc_o          (pc_o),
  .pc_load_o     (pc_load_o),
  .ir_load_o     (ir_load_o),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .ctx_save_o    (ctx_save_o)
);

// File: tb/instr_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb_top;
  localparam int unsigned   AW  = 16;
  localparam logic [AW-1:0] VEC = 16'h0100;

  typedef struct packed {
    logic        mem;
    logic [1:0]  nops;
    logic        st;
    logic        jmp;
    logic        irq;
    logic [1:0]  wt;
    logic [15:0] tgt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000},
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000},
    '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 2'd1, 16'h0000},
    '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 16'h0000},
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0040},
    '{1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 2'd3, 16'h1234},
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0000},
    '{1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 2'd1, 16'h0aaa}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mem_ready_i = 1'b0, has_mem_opnd_i = 1'b0, has_store_i = 1'b0;
  logic          is_jump_i = 1'b0, more_opnd_i = 1'b0, irq_pending_i = 1'b0;
  logic [AW-1:0] jump_target_i = '0;
  logic [8:0]    phase_o;
  logic [AW-1:0] pc_o;
  logic          pc_inc_o, pc_load_o, ir_load_o, mem_rd_o, mem_wr_o, ctx_save_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [AW-1:0] exp_pc = '0;

  always #2 clk_i = ~clk_i;

  instr_cycle_seq #(.AW(AW), .VECTOR(VEC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_ready_i(mem_ready_i),
    .has_mem_opnd_i(has_mem_opnd_i), .has_store_i(has_store_i),
    .is_jump_i(is_jump_i), .more_opnd_i(more_opnd_i),
    .irq_pending_i(irq_pending_i), .jump_target_i(jump_target_i),
    .phase_o(phase_o), .pc_o(pc_o), .pc_inc_o(pc_inc_o),
    .pc_load_o(pc_load_o), .ir_load_o(ir_load_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .ctx_save_o(ctx_save_o)
  );

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  // irqm: 0 never, 1 always, 2 always except during interrupt check
  task automatic run_instr(input logic mem, input int nops, input logic st, input logic jmp,
                           input int irqm, input int w, input logic [AW-1:0] tgt);
    int n = mem ? nops : 0;
    int cyc = 0, rd = 0, wr = 0, ctx = 0, irl = 0, inc = 0, bad = 0, wc = 0, left = n;
    int exp_cyc = 3 + w + n * (2 + w) + 1 + (st ? w + 1 : 0) + 1 + (irqm == 1 ? 1 : 0);
    bit first = 1'b1;
    logic rdy;
    chk(phase_o == 9'd1, "R3 instruction starts in address calculation", phase_o, 1);
    has_mem_opnd_i = mem; has_store_i = st; is_jump_i = jmp; jump_target_i = tgt;
    while ((first || !phase_o[0]) && cyc < 500) begin
      first = 1'b0;
      cyc++;
      rdy = 1'b0;
      if (mem_rd_o || mem_wr_o) begin
        rdy = (wc >= w);
        wc  = rdy ? 0 : wc + 1;
      end
      mem_ready_i = rdy;
      more_opnd_i = 1'b0;
      if (phase_o[4] && rdy) begin
        more_opnd_i = (left > 1);
        left--;
      end
      irq_pending_i = (irqm == 1) ? 1'b1 : (irqm == 2) ? !phase_o[7] : 1'b0;
      #1;
      if (mem_rd_o) rd++;
      if (mem_wr_o) wr++;
      if (ctx_save_o) ctx++;
      if (ir_load_o) irl++;
      if (pc_inc_o) inc++;
      if ($countones(phase_o) != 1) bad++;
      @(negedge clk_i);
    end
    mem_ready_i = 1'b0; more_opnd_i = 1'b0; irq_pending_i = 1'b0;
    chk(cyc == exp_cyc, "R3 R4 R6 R8 cycles per instruction", cyc, exp_cyc);
    chk(rd == (1 + n) * (w + 1), "R4 R6 read request cycles", rd, (1 + n) * (w + 1));
    chk(wr == (st ? w + 1 : 0), "R4 write request cycles", wr, st ? w + 1 : 0);
    chk(irl == 1 && inc == 1, "R5 single IR load and PC increment", irl * 10 + inc, 11);
    chk(bad == 0, "R2 one-hot phase", bad, 0);
    chk(ctx == (irqm == 1 ? 1 : 0), "R9 R10 context save pulses", ctx, irqm == 1 ? 1 : 0);
    exp_pc = jmp ? tgt : exp_pc + AW'(1);
    if (irqm == 1) exp_pc = VEC;
    chk(pc_o == exp_pc, "R5 R7 R9 program counter", pc_o, exp_pc);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(phase_o == 9'd1 && pc_o == '0, "R1 phase and pc in reset", {phase_o, pc_o}, 1 << AW);
    chk(!mem_rd_o && !mem_wr_o && !ctx_save_o, "R1 strobes low in reset",
        {mem_rd_o, mem_wr_o, ctx_save_o}, 0);
    rst_ni = 1'b1;
    #1;
    chk(phase_o == 9'd1 && pc_o == '0, "R1 state after release", phase_o, 1);

    for (int i = 0; i < NV; i++)
      run_instr(VECS[i].mem, int'(VECS[i].nops), VECS[i].st, VECS[i].jmp,
                int'(VECS[i].irq), int'(VECS[i].wt), VECS[i].tgt);

    // R10: request high everywhere except the check phase
    run_instr(1'b1, 2, 1'b1, 1'b0, 2, 1, '0);
    // R8: plain instruction after an interrupt entry
    run_instr(1'b0, 0, 1'b0, 1'b0, 1, 0, '0);
    run_instr(1'b0, 0, 1'b0, 1'b0, 0, 3, '0);

    // R1: asynchronous reset while waiting in operand fetch
    has_mem_opnd_i = 1'b1; mem_ready_i = 1'b1; more_opnd_i = 1'b0;
    for (int i = 0; i < 10 && !phase_o[4]; i++) @(negedge clk_i);
    mem_ready_i = 1'b0;
    @(negedge clk_i);
    chk(phase_o[4] && mem_rd_o, "R4 held in operand fetch without ready", phase_o, 16);
    chk(pc_o != '0, "R1 pc nonzero before reset", pc_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(phase_o == 9'd1 && pc_o == '0, "R1 asynchronous reset clears phase and pc",
        {phase_o, pc_o}, 1 << AW);
    @(negedge clk_i);
    rst_ni = 1'b1; has_mem_opnd_i = 1'b0;
    exp_pc = '0;
    run_instr(1'b0, 0, 1'b1, 1'b1, 0, 0, 16'h0007);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule